// File: doc/BRIEF.md
# Bit test-and-set execution unit

This unit executes the "copy one bit into carry, then force it to one" operation on a register destination. Decode has already split the instruction, so the unit receives two opcode bytes, the 3-bit register-selector field of the addressing byte, a flag telling whether the destination is a register, the operand-size controls, the atomic-prefix flag, an 8-bit immediate, the current destination value, the offset-register value and the incoming carry and zero flags. From these it finds the encoding and the operand size, selects the addressed bit, and returns the updated destination together with the new flags one clock later.

Two encodings are claimed. In the register-offset form the offset comes from a register. In the immediate-offset form the offset comes from the immediate byte, and this form is only valid when the selector field holds sub-opcode 5. Any other encoding, and any memory destination, is reported as foreign and passed through unchanged so that another unit can handle it. An atomic prefix on a register destination is illegal. The unit then raises an invalid-opcode fault and changes nothing.

Top module: `bit_set_unit`

## Requirements
- R1: Opcode bytes 0x0F then 0xAB with a register destination select the register-offset form: the bit offset is taken from `off_val_i`.
- R2: Opcode bytes 0x0F then 0xBA with selector field 5 and a register destination select the immediate-offset form: the bit offset is taken from `imm_i`.
- R3: On an executed operation, `cf_o` equals the value the selected bit had in `dst_i`, and that bit of `result_o` is 1.
- R4: `zf_o` always equals `zf_i` from the same transaction. The undefined flags `misc_flags_o` are driven to zero.
- R5: The operand size is 64 when `wide64_i` is 1, else 16 when `half16_i` is 1, else 32. The offset is the source reduced modulo the size, using its low 4, 5 or 6 bits.
- R6: With a 32-bit size, `result_o[63:32]` is zero. With a 16-bit size, `result_o[63:16]` equals `dst_i[63:16]`. Below the size, only the selected bit may change.
- R7: A claimed encoding with `atomic_i` = 1 and a register destination sets `ud_fault_o`. `result_o` then equals `dst_i` and `cf_o` equals `cf_i`.
- R8: Any other opcode, 0x0F 0xBA with a selector other than 5, or `dst_is_reg_i` = 0 sets `foreign_o`. `ud_fault_o` stays low, `result_o` equals `dst_i` and `cf_o` equals `cf_i`.
- R9: Results appear one clock after `in_valid_i`, and `out_valid_o` follows `in_valid_i` with one cycle of delay. While reset is active, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Transaction present on the inputs |
| op_hi_i | input | 8 | First opcode byte |
| op_lo_i | input | 8 | Second opcode byte |
| sel_i | input | 3 | Register-selector field of the addressing byte |
| dst_is_reg_i | input | 1 | Destination operand is a register |
| wide64_i | input | 1 | Promote the operation to 64 bits |
| half16_i | input | 1 | Operand-size override to 16 bits |
| atomic_i | input | 1 | Atomic prefix present |
| imm_i | input | 8 | Immediate offset byte |
| dst_i | input | 64 | Current destination value |
| off_val_i | input | 64 | Offset register value |
| cf_i | input | 1 | Incoming carry flag |
| zf_i | input | 1 | Incoming zero flag |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 64 | Value to write back to the destination |
| cf_o | output | 1 | New carry flag |
| zf_o | output | 1 | Zero flag, passed through |
| misc_flags_o | output | 4 | Undefined flags (overflow, sign, adjust, parity), driven zero |
| ud_fault_o | output | 1 | Invalid-opcode fault |
| foreign_o | output | 1 | Encoding not handled by this unit |

## Verification
The hardest case to reach is an offset wrap. The source offset is at or above the operand size, so the addressed bit must come from only the low 4 or 5 bits, and in 16-bit mode the bits above the operand must survive while the low word changes. The stimulus covers this directly. It sweeps every immediate value from 0 to 255 and every register offset from 0 to 255, with junk in the upper offset bits, for all three sizes, over all-zero, all-one and patterned destinations. Every case is compared with an arithmetic model. Separate passes flip the atomic flag, the selector field, the opcode bytes and the destination kind to reach the fault and foreign paths.

// File: rtl/bit_set_pkg.sv
// Package: shared encodings and enumerations for the bit test-and-set unit.
// Assumes a two-byte opcode already split out by the front-end decoder.
package bit_set_pkg;
    localparam logic [7:0] ESC_BYTE    = 8'h0F;
    localparam logic [7:0] REG_FORM_OP = 8'hAB;
    localparam logic [7:0] IMM_FORM_OP = 8'hBA;
    localparam logic [2:0] IMM_SUBOP   = 3'd5;

    typedef enum logic [1:0] {
        SZ_16 = 2'd0,
        SZ_32 = 2'd1,
        SZ_64 = 2'd2
    } opsize_e;

    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_REG  = 2'd1,
        FORM_IMM  = 2'd2
    } form_e;
endpackage

// File: rtl/bit_set_decode.sv
// Module: bit_set_decode
// Classifies the pre-split instruction fields. It recognises the register-offset
// and immediate-offset encodings, picks the operand size, and resolves the
// outcome: execute, invalid-opcode fault, or foreign.
// Assumes that size promotion to 64 bits overrides the 16-bit override.
module bit_set_decode
    import bit_set_pkg::*;
(
    input  logic [7:0] op_hi,
    input  logic [7:0] op_lo,
    input  logic [2:0] sel,
    input  logic       dst_is_reg,
    input  logic       wide64,
    input  logic       half16,
    input  logic       atomic,
    output form_e      form,
    output opsize_e    size,
    output logic       execute,
    output logic       ud,
    output logic       foreign
);
    logic is_reg_op;
    logic is_imm_op;

    // Recognise the two claimed opcode patterns.
    always_comb begin
        is_reg_op = (op_hi == ESC_BYTE) && (op_lo == REG_FORM_OP);
        is_imm_op = (op_hi == ESC_BYTE) && (op_lo == IMM_FORM_OP) && (sel == IMM_SUBOP);
        if (is_reg_op)      form = FORM_REG;
        else if (is_imm_op) form = FORM_IMM;
        else                form = FORM_NONE;
    end

    // Operand size selection: promotion first, then the 16-bit override.
    always_comb begin
        if (wide64)      size = SZ_64;
        else if (half16) size = SZ_16;
        else             size = SZ_32;
    end

    // Outcome resolution: foreign, then atomic legality, then execute.
    always_comb begin
        foreign = 1'b0;
        ud      = 1'b0;
        execute = 1'b0;
        if ((form == FORM_NONE) || !dst_is_reg) foreign = 1'b1;
        else if (atomic)                        ud      = 1'b1;
        else                                    execute = 1'b1;
    end
endmodule

// File: rtl/bit_set_core.sv
// Module: bit_set_core
// Datapath: reduces the offset modulo the operand size, reads the old bit,
// sets it, and merges the result with the old destination lane by lane
// according to the size-specific write rule.
// Assumes DATA_W is a multiple of 2*LANE_W and LANE_W is the smallest size.
module bit_set_core
    import bit_set_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16
) (
    input  form_e              form,
    input  opsize_e            size,
    input  logic [DATA_W-1:0]  dst,
    input  logic [DATA_W-1:0]  offv,
    input  logic [7:0]         imm,
    output logic [DATA_W-1:0]  merged,
    output logic               old_bit
);
    localparam int OFF_W      = $clog2(DATA_W);
    localparam int LANES      = DATA_W / LANE_W;
    localparam int HALF_LANES = (DATA_W / 2) / LANE_W;
    localparam logic [DATA_W-1:0] MASK_SMALL = DATA_W'(LANE_W - 1);
    localparam logic [DATA_W-1:0] MASK_MID   = DATA_W'(DATA_W / 2 - 1);
    localparam logic [DATA_W-1:0] MASK_FULL  = DATA_W'(DATA_W - 1);

    logic [DATA_W-1:0] src_ext;
    logic [DATA_W-1:0] size_mask;
    logic [OFF_W-1:0]  sel_off;
    logic [DATA_W-1:0] set_val;

    // Pick the offset source and the modulo mask for the current size.
    always_comb begin
        src_ext = (form == FORM_IMM) ? DATA_W'(imm) : offv;
        case (size)
            SZ_16:   size_mask = MASK_SMALL;
            SZ_32:   size_mask = MASK_MID;
            default: size_mask = MASK_FULL;
        endcase
        sel_off = OFF_W'(src_ext & size_mask);
    end

    // Read the addressed bit and form the fully set value.
    always_comb begin
        old_bit = dst[sel_off];
        set_val = dst | (DATA_W'(1) << sel_off);
    end

    // Lane merge: the lowest lane always takes the new value; the upper lanes
    // follow the write rule of the size.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LO = g * LANE_W;
        if (g == 0) begin : g_base
            assign merged[LO +: LANE_W] = set_val[LO +: LANE_W];
        end else if (g < HALF_LANES) begin : g_mid
            assign merged[LO +: LANE_W] = (size == SZ_16) ? dst[LO +: LANE_W]
                                                          : set_val[LO +: LANE_W];
        end else begin : g_top
            assign merged[LO +: LANE_W] = (size == SZ_16) ? dst[LO +: LANE_W] :
                                          (size == SZ_32) ? '0 :
                                                            set_val[LO +: LANE_W];
        end
    end
endmodule

// File: rtl/bit_set_unit.sv
// Module: bit_set_unit (top)
// Bit test-and-set on a register destination, with a registered output stage.
// Combines decode and datapath, selects pass-through values on a fault or a
// foreign encoding, and registers everything one cycle after in_valid_i.
// Assumes memory destinations are handled by another unit.
module bit_set_unit
    import bit_set_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [7:0]        op_hi_i,
    input  logic [7:0]        op_lo_i,
    input  logic [2:0]        sel_i,
    input  logic              dst_is_reg_i,
    input  logic              wide64_i,
    input  logic              half16_i,
    input  logic              atomic_i,
    input  logic [7:0]        imm_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] off_val_i,
    input  logic              cf_i,
    input  logic              zf_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic              cf_o,
    output logic              zf_o,
    output logic [3:0]        misc_flags_o,
    output logic              ud_fault_o,
    output logic              foreign_o
);
    form_e             form;
    opsize_e           size;
    logic              execute;
    logic              ud;
    logic              foreign;
    logic [DATA_W-1:0] merged;
    logic              old_bit;
    logic [DATA_W-1:0] next_val;
    logic              next_cf;

    bit_set_decode u_decode (
        .op_hi      (op_hi_i),
        .op_lo      (op_lo_i),
        .sel        (sel_i),
        .dst_is_reg (dst_is_reg_i),
        .wide64     (wide64_i),
        .half16     (half16_i),
        .atomic     (atomic_i),
        .form       (form),
        .size       (size),
        .execute    (execute),
        .ud         (ud),
        .foreign    (foreign)
    );

    bit_set_core #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_core (
        .form    (form),
        .size    (size),
        .dst     (dst_i),
        .offv    (off_val_i),
        .imm     (imm_i),
        .merged  (merged),
        .old_bit (old_bit)
    );

    // Choose between the executed result and the unchanged pass-through.
    always_comb begin
        next_val = execute ? merged  : dst_i;
        next_cf  = execute ? old_bit : cf_i;
    end

    // Output stage: capture on valid input; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            result_o    <= '0;
            cf_o        <= 1'b0;
            zf_o        <= 1'b0;
            ud_fault_o  <= 1'b0;
            foreign_o   <= 1'b0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                result_o   <= next_val;
                cf_o       <= next_cf;
                zf_o       <= zf_i;
                ud_fault_o <= ud;
                foreign_o  <= foreign;
            end
        end
    end

    // Undefined flags: this design drives them low.
    assign misc_flags_o = 4'b0000;
endmodule

// File: rtl/bit_set_unit_chk.sv
// Module: bit_set_unit_chk
// Checks temporal properties at the ports of bit_set_unit. It is attached by
// the bind statement at the end of this file.
module bit_set_unit_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid_i,
    input logic              wide64_i,
    input logic              half16_i,
    input logic [DATA_W-1:0] dst_i,
    input logic              cf_i,
    input logic              zf_i,
    input logic              out_valid_o,
    input logic [DATA_W-1:0] result_o,
    input logic              cf_o,
    input logic              zf_o,
    input logic              ud_fault_o,
    input logic              foreign_o
);
    // out_valid_o follows in_valid_i one cycle later (R9).
    a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);
    a_r9_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o);

    // The zero flag passes through (R4).
    a_r4_zf_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> (zf_o == $past(zf_i)));

    // A fault leaves the destination and carry untouched (R7).
    a_r7_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> (ud_fault_o |-> (result_o == $past(dst_i) && cf_o == $past(cf_i))));

    // A foreign encoding passes through and never faults (R8).
    a_r8_foreign_pass: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> (foreign_o |-> (!ud_fault_o && result_o == $past(dst_i) && cf_o == $past(cf_i))));

    // Executed: the low lane only gains bits, at most one of them (R3).
    a_r3_low_lane_one_set: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> ((!ud_fault_o && !foreign_o) |->
            (((result_o[15:0] & $past(dst_i[15:0])) == $past(dst_i[15:0])) &&
             ($countones(result_o[15:0] ^ $past(dst_i[15:0])) <= 1))));

    // Executed with a 32-bit size: the upper half is cleared (R6).
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !wide64_i && !half16_i) |=>
            ((!ud_fault_o && !foreign_o) |-> (result_o[DATA_W-1:DATA_W/2] == '0)));

    // Executed with a 16-bit size: bits above the operand are kept (R6).
    a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !wide64_i && half16_i) |=>
            ((!ud_fault_o && !foreign_o) |-> (result_o[DATA_W-1:16] == $past(dst_i[DATA_W-1:16]))));
endmodule

bind bit_set_unit bit_set_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bit_set_unit_bench.sv
// Bench: sweeps offsets, sizes, forms and destination patterns, and checks
// every result against an arithmetic model one clock after it is driven.
`timescale 1ns/1ps
module bit_set_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [7:0]  op_hi_i = '0, op_lo_i = '0, imm_i = '0;
    logic [2:0]  sel_i = '0;
    logic        dst_is_reg_i = 1'b0, wide64_i = 1'b0, half16_i = 1'b0, atomic_i = 1'b0;
    logic [63:0] dst_i = '0, off_val_i = '0;
    logic        cf_i = 1'b0, zf_i = 1'b0;
    logic        out_valid_o;
    logic [63:0] result_o;
    logic        cf_o, zf_o, ud_fault_o, foreign_o;
    logic [3:0]  misc_flags_o;

    int checks = 0;
    int failures = 0;

    bit_set_unit u_bit_set_unit (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one transaction and check it at the next falling edge.
    task automatic run_op(input logic [7:0] hi, input logic [7:0] lo, input logic [2:0] sl,
                          input logic isreg, input logic w64, input logic h16, input logic atom,
                          input logic [7:0] imm, input logic [63:0] d, input logic [63:0] ov,
                          input logic ci, input logic zi);
        logic claimed, imm_form, exec, ud, fr, oldb;
        int sz, off;
        logic [63:0] setv, expv;
        op_hi_i = hi; op_lo_i = lo; sel_i = sl; dst_is_reg_i = isreg; wide64_i = w64;
        half16_i = h16; atomic_i = atom; imm_i = imm; dst_i = d; off_val_i = ov;
        cf_i = ci; zf_i = zi; in_valid_i = 1'b1;
        imm_form = (hi == 8'h0F) && (lo == 8'hBA) && (sl == 3'd5);
        claimed  = ((hi == 8'h0F) && (lo == 8'hAB)) || imm_form;
        fr   = !claimed || !isreg;
        ud   = !fr && atom;
        exec = !fr && !atom;
        sz   = w64 ? 64 : (h16 ? 16 : 32);
        off  = (imm_form ? int'(imm) : int'(ov[7:0])) % sz;
        oldb = d[off];
        setv = d | (64'd1 << off);
        if (!exec)         expv = d;
        else if (sz == 64) expv = setv;
        else if (sz == 32) expv = {32'd0, setv[31:0]};
        else               expv = {d[63:16], setv[15:0]};
        @(negedge clk);
        chk("R9 out_valid", 64'(out_valid_o), 64'd1);
        chk("R8 foreign", 64'(foreign_o), 64'(fr));
        chk("R7 ud_fault", 64'(ud_fault_o), 64'(ud));
        if (exec && sz != 64) chk("R6 result write rule", result_o, expv);
        else if (exec)        chk(imm_form ? "R2 result imm form" : "R1 result reg form", result_o, expv);
        else                  chk(ud ? "R7 result kept" : "R8 result kept", result_o, expv);
        if (exec) chk(sz == 16 ? "R5 carry 16" : "R3 carry", 64'(cf_o), 64'(oldb));
        else      chk("R7 R8 carry kept", 64'(cf_o), 64'(ci));
        chk("R4 zero flag", 64'(zf_o), 64'(zi));
        chk("R4 misc flags", 64'(misc_flags_o), 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] pats [3];
        pats[0] = 64'd0;
        pats[1] = '1;
        pats[2] = 64'hA55A_3CC3_0FF0_9669;
        repeat (3) @(negedge clk);
        in_valid_i = 1'b1;
        @(negedge clk);
        // R9: reset holds outputs at zero even with input valid.
        chk("R9 reset valid", 64'(out_valid_o), 64'd0);
        chk("R9 reset result", result_o, 64'd0);
        chk("R9 reset flags", {60'd0, cf_o, zf_o, ud_fault_o, foreign_o}, 64'd0);
        in_valid_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R5 R6: full offset sweep for all sizes, forms and patterns.
        for (int s = 0; s < 3; s++)
            for (int f = 0; f < 2; f++)
                for (int p = 0; p < 3; p++)
                    for (int o = 0; o < 256; o++)
                        run_op(8'h0F, f ? 8'hBA : 8'hAB, f ? 3'd5 : 3'(o),
                               1'b1, s == 2, s == 0, 1'b0, 8'(o),
                               pats[p] ^ (64'(o) << 40),
                               {24'hC0FFEE, 32'(o * 977), 8'(o)} ,
                               o[0], o[1]);

        // R7: atomic prefix with a register destination, both forms.
        for (int o = 0; o < 16; o++)
            run_op(8'h0F, o[0] ? 8'hBA : 8'hAB, 3'd5, 1'b1, o[1], o[2], 1'b1,
                   8'(o * 3), pats[2] >> o, 64'(o), o[3], ~o[3]);

        // R8: sub-opcodes other than 5, other opcodes, memory destinations.
        for (int sl = 0; sl < 8; sl++)
            run_op(8'h0F, 8'hBA, 3'(sl), 1'b1, 1'b1, 1'b0, 1'b0, 8'd7, 64'h1234, 64'd0, 1'b1, 1'b0);
        run_op(8'h0F, 8'hAC, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 64'h55, 64'd3, 1'b0, 1'b1);
        run_op(8'h0E, 8'hAB, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 64'h55, 64'd3, 1'b1, 1'b1);
        run_op(8'h0F, 8'hAB, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd1, 64'h55, 64'd3, 1'b1, 1'b0);
        run_op(8'h0F, 8'hBA, 3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2, 64'h0, 64'd0, 1'b0, 1'b0);

        // R9: idle cycle drops out_valid_o.
        in_valid_i = 1'b0;
        @(negedge clk);
        chk("R9 idle valid", 64'(out_valid_o), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule